// File: doc/BRIEF.md
# Profile-Switched DDS Phase Core

This block is the digital core of a direct digital synthesizer. Each clock it steps a phase accumulator by a tuning word. It adds a phase offset to the upper phase bits, turns the phase into a signed sine sample through a quarter-wave table, and scales that sample by an amplitude factor. The result is a 12-bit signed value for a downstream converter. The accumulator can wrap at a programmed modulus, which gives exact frequency ratios that are not powers of two.

The core holds eight profiles. Each profile has its own tuning word, phase offset and amplitude factor. A 3-bit select input picks the profile in use. Software writes land in shadow copies and have no effect on the output until they are committed. A commit happens on an explicit update strobe, or when the profile select changes value. In both cases every shadow value, together with the modulus settings, moves into the active set on the same clock edge.

Top module: `dds_profile_core`

## Requirements
- R1: While `rst` is high at a rising edge, the accumulator, the pipeline, every shadow and active register, and the modulus settings clear to zero, and profile 0 becomes active. After that edge, `phaseAcc` and `sampleOut` read 0.
- R2: With the modulus disabled, each edge sets the accumulator to the accumulator plus the active tuning word, modulo 2^32.
- R3: With the modulus enabled, the 33-bit sum is reduced by the modulus M whenever the sum is at least M. If both the tuning word and the accumulator are below M, the accumulator stays below M.
- R4: Writes change only shadow registers. `wrAddr[5]`=0 addresses profile `wrAddr[4:2]`, and `wrAddr[1:0]` selects the field: 0 is the tuning word (32 bits), 1 is the phase offset (bits 15:0), 2 is the amplitude (bits 11:0), and 3 is ignored. `wrAddr[5]`=1 selects a global field: `wrAddr[0]`=0 is the modulus (32 bits) and `wrAddr[0]`=1 is the modulus enable (bit 0). A write with no commit leaves the output unchanged.
- R5: When `updateStrobe` is high at an edge, all shadow values are copied to the active set. A write issued in that same cycle reaches only the shadow set.
- R6: If `profileSel` differs from the registered profile at an edge, that edge commits all shadows exactly as R5 does and makes the new profile the active one.
- R7: The table is addressed by the top 8 bits k of the 16-bit phase, which is the upper 16 accumulator bits plus the phase offset, modulo 2^16. The table value is round(2047·sin(2π(k+0.5)/256)), with the magnitude rounded half up.
- R8: The sample is floor((s·a + 2048)/4096), where s is the table value and a is the 12-bit unsigned amplitude. An amplitude of 0 gives 0, and the sample is never −2048.
- R9: `sampleOut` reflects the accumulator value and active profile values from two edges earlier. The table lookup is registered at the first edge and the scaling at the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 6 | Register write address |
| wrData | input | 32 | Register write data |
| updateStrobe | input | 1 | Commit all shadow registers |
| profileSel | input | 3 | Active profile select |
| phaseAcc | output | 32 | Phase accumulator value |
| sampleOut | output | 12 | Signed scaled sine sample |

## Verification
The embedded properties check on every clock the following. The active profile values stay put unless a commit occurs. The accumulator stays below the modulus when its inputs allow. A zero amplitude drives the next sample to zero, the sample never reaches the most negative code, and reset clears the state. Other behaviour needs stimulus to show: the exact sine values, the rounding of the product, the two-edge latency, and the rule that a write in a commit cycle lands only in the shadow set. The bench checks these with a cycle-accurate reference model over directed sequences and randomized writes, profile changes and resets.

// File: rtl/dds_pkg.sv
package dds_pkg;
  parameter int ACC_W    = 32;
  parameter int PHASE_W  = 16;
  parameter int AMP_W    = 12;
  parameter int OUT_W    = 12;
  parameter int NPROF    = 8;
  parameter int LUT_BITS = 6;

  localparam int PROF_W = $clog2(NPROF);
  localparam int ADDR_W = PROF_W + 3;

  typedef struct packed {
    logic              commit;
    logic [PROF_W-1:0] prof;
  } ctlStrobe_t;
endpackage

// File: rtl/dds_ctrl.sv
module dds_ctrl
  import dds_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              updateStrobe,
  input  logic [PROF_W-1:0] profileSel,
  output ctlStrobe_t        ctl
);
  logic [PROF_W-1:0] profQ;

  always_ff @(posedge clk) begin
    if (rst) profQ <= '0;
    else     profQ <= profileSel;
  end

  assign ctl.commit = !rst && (updateStrobe || (profileSel != profQ));
  assign ctl.prof   = profQ;

  a_r1_profile_reset: assert property (@(posedge clk) rst |=> (ctl.prof == '0));

  a_r6_profile_switch: assert property (@(posedge clk) disable iff (rst)
    (profileSel != ctl.prof) |=> (ctl.prof == $past(profileSel)));
endmodule

// File: rtl/dds_regbank.sv
module dds_regbank
  import dds_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobe_t        ctl,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ACC_W-1:0]  wrData,
  output logic [ACC_W-1:0]  ftwSel,
  output logic [PHASE_W-1:0] poffSel,
  output logic [AMP_W-1:0]  ampSel,
  output logic [ACC_W-1:0]  modVal,
  output logic              modEn
);
  logic [ACC_W-1:0]   shFtw  [NPROF];
  logic [PHASE_W-1:0] shPoff [NPROF];
  logic [AMP_W-1:0]   shAmp  [NPROF];
  logic [ACC_W-1:0]   acFtw  [NPROF];
  logic [PHASE_W-1:0] acPoff [NPROF];
  logic [AMP_W-1:0]   acAmp  [NPROF];
  logic [ACC_W-1:0]   shMod, acMod;
  logic               shModEn, acModEn;

  logic              isGlobal;
  logic [PROF_W-1:0] wrProf;
  logic [1:0]        wrField;

  assign isGlobal = wrAddr[ADDR_W-1];
  assign wrProf   = wrAddr[ADDR_W-2:2];
  assign wrField  = wrAddr[1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPROF; i++) begin
        shFtw[i]  <= '0; shPoff[i] <= '0; shAmp[i] <= '0;
        acFtw[i]  <= '0; acPoff[i] <= '0; acAmp[i] <= '0;
      end
      shMod <= '0; acMod <= '0; shModEn <= 1'b0; acModEn <= 1'b0;
    end else begin
      if (ctl.commit) begin
        for (int i = 0; i < NPROF; i++) begin
          acFtw[i]  <= shFtw[i];
          acPoff[i] <= shPoff[i];
          acAmp[i]  <= shAmp[i];
        end
        acMod   <= shMod;
        acModEn <= shModEn;
      end
      if (wrEn) begin
        if (isGlobal) begin
          if (wrField[0]) shModEn <= wrData[0];
          else            shMod   <= wrData;
        end else begin
          case (wrField)
            2'd0:    shFtw[wrProf]  <= wrData;
            2'd1:    shPoff[wrProf] <= wrData[PHASE_W-1:0];
            2'd2:    shAmp[wrProf]  <= wrData[AMP_W-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  assign ftwSel  = acFtw[ctl.prof];
  assign poffSel = acPoff[ctl.prof];
  assign ampSel  = acAmp[ctl.prof];
  assign modVal  = acMod;
  assign modEn   = acModEn;

  a_r4_active_hold: assert property (@(posedge clk) disable iff (rst)
    !ctl.commit |=> ($stable(ftwSel) && $stable(poffSel) && $stable(ampSel)
                     && $stable(modVal) && $stable(modEn)));
endmodule

// File: rtl/dds_datapath.sv
module dds_datapath
  import dds_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [ACC_W-1:0]   ftw,
  input  logic [PHASE_W-1:0] poff,
  input  logic [AMP_W-1:0]   amp,
  input  logic [ACC_W-1:0]   modVal,
  input  logic               modEn,
  output logic [ACC_W-1:0]   accOut,
  output logic [OUT_W-1:0]   sampleOut
);
  localparam int QSIZE = 1 << LUT_BITS;
  localparam int FULL  = (1 << (OUT_W-1)) - 1;
  localparam int PW    = OUT_W + AMP_W + 1;
  localparam logic signed [PW-1:0] RNDV = PW'(1 << (AMP_W-1));

  logic [OUT_W-1:0] lut [QSIZE];

  for (genvar i = 0; i < QSIZE; i++) begin : g_lut
    localparam real ANG = 1.5707963267948966 * (real'(i) + 0.5) / real'(QSIZE);
    localparam int  MAG = $rtoi(real'(FULL) * $sin(ANG) + 0.5);
    assign lut[i] = OUT_W'(MAG);
  end

  logic [ACC_W-1:0]   accQ, accNext;
  logic [ACC_W:0]     sum;
  logic [PHASE_W-1:0] phase;
  logic [LUT_BITS+1:0] tIdx;
  logic [LUT_BITS-1:0] mirIdx;
  logic signed [OUT_W-1:0] mag, sineVal, sineQ, sampleQ;
  logic [AMP_W-1:0] ampQ;
  logic signed [PW-1:0] prod, scaled;

  assign sum     = {1'b0, accQ} + {1'b0, ftw};
  assign accNext = (modEn && (sum >= {1'b0, modVal})) ? ACC_W'(sum - {1'b0, modVal})
                                                      : ACC_W'(sum);

  assign phase   = accQ[ACC_W-1 -: PHASE_W] + poff;
  assign tIdx    = phase[PHASE_W-1 -: LUT_BITS+2];
  assign mirIdx  = tIdx[LUT_BITS] ? ~tIdx[LUT_BITS-1:0] : tIdx[LUT_BITS-1:0];
  assign mag     = lut[mirIdx];
  assign sineVal = tIdx[LUT_BITS+1] ? -mag : mag;

  assign prod    = PW'(sineQ) * $signed({1'b0, ampQ});
  assign scaled  = (prod + RNDV) >>> AMP_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      accQ    <= '0;
      sineQ   <= '0;
      ampQ    <= '0;
      sampleQ <= '0;
    end else begin
      accQ    <= accNext;
      sineQ   <= sineVal;
      ampQ    <= amp;
      sampleQ <= scaled[OUT_W-1:0];
    end
  end

  assign accOut    = accQ;
  assign sampleOut = sampleQ;

  a_r1_pipe_reset: assert property (@(posedge clk)
    rst |=> (accQ == '0 && sineQ == '0 && sampleQ == '0));

  a_r3_below_modulus: assert property (@(posedge clk) disable iff (rst)
    (modEn && ftw < modVal && accQ < modVal) |=> (accQ < $past(modVal)));

  a_r8_zero_amplitude: assert property (@(posedge clk) disable iff (rst)
    (ampQ == '0) |=> (sampleQ == '0));

  a_r8_no_min_code: assert property (@(posedge clk) disable iff (rst)
    sampleQ != {1'b1, {(OUT_W-1){1'b0}}});
endmodule

// File: rtl/dds_profile_core.sv
module dds_profile_core (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wrEn,
  input  logic [dds_pkg::ADDR_W-1:0]    wrAddr,
  input  logic [dds_pkg::ACC_W-1:0]     wrData,
  input  logic                          updateStrobe,
  input  logic [dds_pkg::PROF_W-1:0]    profileSel,
  output logic [dds_pkg::ACC_W-1:0]     phaseAcc,
  output logic [dds_pkg::OUT_W-1:0]     sampleOut
);
  import dds_pkg::*;

  ctlStrobe_t         ctl;
  logic [ACC_W-1:0]   ftwSel, modVal;
  logic [PHASE_W-1:0] poffSel;
  logic [AMP_W-1:0]   ampSel;
  logic               modEn;

  dds_ctrl u_ctrl (
    .clk(clk), .rst(rst), .updateStrobe(updateStrobe),
    .profileSel(profileSel), .ctl(ctl)
  );

  dds_regbank u_regs (
    .clk(clk), .rst(rst), .ctl(ctl), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .ftwSel(ftwSel), .poffSel(poffSel), .ampSel(ampSel),
    .modVal(modVal), .modEn(modEn)
  );

  dds_datapath u_dp (
    .clk(clk), .rst(rst), .ftw(ftwSel), .poff(poffSel), .amp(ampSel),
    .modVal(modVal), .modEn(modEn), .accOut(phaseAcc), .sampleOut(sampleOut)
  );
endmodule

// File: tb/sim_dds_profile_core.sv
module sim_dds_profile_core;
  logic        clk = 1'b0;
  logic        rstI = 1'b1;
  logic        wrEnI = 1'b0;
  logic [5:0]  wrAddrI = '0;
  logic [31:0] wrDataI = '0;
  logic        updI = 1'b0;
  logic [2:0]  pselI = '0;
  logic [31:0] phaseAcc;
  logic [11:0] sampleOut;

  int checks = 0;
  int fails = 0;
  string curReq = "R1";

  always #4 clk = ~clk;

  dds_profile_core u0 (
    .clk(clk), .rst(rstI), .wrEn(wrEnI), .wrAddr(wrAddrI), .wrData(wrDataI),
    .updateStrobe(updI), .profileSel(pselI), .phaseAcc(phaseAcc), .sampleOut(sampleOut)
  );

  // reference model state
  logic [31:0] shFtw [8], acFtw [8], shMod, acMod;
  logic [15:0] shPoff [8], acPoff [8];
  logic [11:0] shAmp [8], acAmp [8];
  logic        shModEn, acModEn;
  logic [2:0]  mProf;
  logic [31:0] mAcc;
  int          mSine, mAmpP, mSample;

  function automatic int sineRef(input logic [7:0] k);
    real a, v;
    a = 6.283185307179586 * (real'(k) + 0.5) / 256.0;
    v = 2047.0 * $sin(a);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  function automatic int scaleRef(input int s, input int a);
    return (s * a + 2048) >>> 12;
  endfunction

  task automatic modelClear();
    for (int i = 0; i < 8; i++) begin
      shFtw[i] = '0; acFtw[i] = '0; shPoff[i] = '0;
      acPoff[i] = '0; shAmp[i] = '0; acAmp[i] = '0;
    end
    shMod = '0; acMod = '0; shModEn = 1'b0; acModEn = 1'b0;
    mProf = '0; mAcc = '0; mSine = 0; mAmpP = 0; mSample = 0;
  endtask

  task automatic modelEdge();
    logic        commit;
    logic [32:0] s;
    logic [31:0] accN;
    logic [15:0] ph;
    int          sineN, ampN, sampN;
    if (rstI) begin
      modelClear();
      return;
    end
    commit = updI || (pselI != mProf);
    s = {1'b0, mAcc} + {1'b0, acFtw[mProf]};
    if (acModEn && s >= {1'b0, acMod}) s = s - {1'b0, acMod};
    accN  = s[31:0];
    ph    = mAcc[31:16] + acPoff[mProf];
    sineN = sineRef(ph[15:8]);
    ampN  = int'(acAmp[mProf]);
    sampN = scaleRef(mSine, mAmpP);
    if (commit) begin
      for (int i = 0; i < 8; i++) begin
        acFtw[i] = shFtw[i]; acPoff[i] = shPoff[i]; acAmp[i] = shAmp[i];
      end
      acMod = shMod; acModEn = shModEn;
    end
    if (wrEnI) begin
      if (wrAddrI[5]) begin
        if (wrAddrI[0]) shModEn = wrDataI[0];
        else            shMod   = wrDataI;
      end else begin
        case (wrAddrI[1:0])
          2'd0: shFtw[wrAddrI[4:2]]  = wrDataI;
          2'd1: shPoff[wrAddrI[4:2]] = wrDataI[15:0];
          2'd2: shAmp[wrAddrI[4:2]]  = wrDataI[11:0];
          default: ;
        endcase
      end
    end
    mProf = pselI; mAcc = accN; mSine = sineN; mAmpP = ampN; mSample = sampN;
  endtask

  task automatic checkOut();
    checks++;
    if (phaseAcc !== mAcc) begin
      fails++;
      $display("FAIL %s: phaseAcc=%h expected %h", curReq, phaseAcc, mAcc);
    end
    checks++;
    if (int'($signed(sampleOut)) != mSample) begin
      fails++;
      $display("FAIL %s: sampleOut=%0d expected %0d", curReq, $signed(sampleOut), mSample);
    end
  endtask

  // one clock: model at the edge, compare mid-cycle, release pulses
  task automatic step();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    checkOut();
    wrEnI = 1'b0;
    updI  = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wrProf(input logic [2:0] p, input logic [1:0] f, input logic [31:0] d);
    wrEnI = 1'b1; wrAddrI = {1'b0, p, f}; wrDataI = d;
    step();
  endtask

  task automatic wrGlob(input logic sel, input logic [31:0] d);
    wrEnI = 1'b1; wrAddrI = {5'b10000, sel}; wrDataI = d;
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: cycles exhausted, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    modelClear();
    @(negedge clk);
    // R1: reset state
    curReq = "R1";
    run(3);
    rstI = 1'b0;
    run(3);

    // R4: writes without commit leave output untouched
    curReq = "R4";
    wrProf(3'd0, 2'd0, 32'h0100_0000);
    wrProf(3'd0, 2'd2, 32'hFFFF_FFFF);
    wrProf(3'd0, 2'd3, 32'h1234_5678);
    run(4);

    // R5: update strobe commits; R7/R9 follow from sweep
    curReq = "R5";
    updI = 1'b1;
    step();
    curReq = "R7";
    run(300);

    // R2: power-of-two wrap with a large step
    curReq = "R2";
    wrProf(3'd0, 2'd0, 32'hF000_0001);
    updI = 1'b1; step();
    run(40);

    // R3: modulus wrap
    curReq = "R3";
    wrGlob(1'b0, 32'd1_000_000_000);
    wrGlob(1'b1, 32'd1);
    wrProf(3'd0, 2'd0, 32'd300_000_000);
    updI = 1'b1; step();
    run(60);

    // R6: profile change commits buffered writes and switches
    curReq = "R6";
    wrProf(3'd5, 2'd0, 32'h0040_0000);
    wrProf(3'd5, 2'd1, 32'h0000_4000);
    wrProf(3'd5, 2'd2, 32'h0000_0800);
    pselI = 3'd5; step();
    run(20);

    // R5 corner: write in the commit cycle stays in the shadow set
    curReq = "R5";
    wrEnI = 1'b1; wrAddrI = {1'b0, 3'd5, 2'd2}; wrDataI = 32'd4095; updI = 1'b1;
    step();
    run(10);
    updI = 1'b1; step();
    run(10);

    // R8: zero amplitude
    curReq = "R8";
    wrProf(3'd5, 2'd2, 32'd0);
    updI = 1'b1; step();
    run(10);

    // R9: switch back to profile 0 and observe pipeline
    curReq = "R9";
    pselI = 3'd0; step();
    run(10);

    // randomized mix
    curReq = "R7";
    for (int i = 0; i < 6000; i++) begin
      rstI    = ($urandom % 700) == 0;
      wrEnI   = ($urandom % 10) < 3;
      wrAddrI = 6'($urandom);
      wrDataI = $urandom;
      if (($urandom % 4) == 0) wrDataI = wrDataI >> 4;
      updI    = ($urandom % 20) == 0;
      if (($urandom % 25) == 0) pselI = 3'($urandom);
      step();
    end
    rstI = 1'b0;

    // R1 again at the end
    curReq = "R1";
    rstI = 1'b1; step();
    rstI = 1'b0; run(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule